// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer with Pulse or Level Interrupt

This block is an 8-bit reloadable down-counter. It advances on one of four slow tick enables that a clock generator outside the block supplies: 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz. Software writes a start value. While enabled, the counter steps down on each selected tick. When it reaches zero it raises a sticky flag, waits one tick at zero, reloads the last written value and keeps running.

Three registers sit behind a plain address, write-data and read-data port: a flag register, a value register and a control register. Reading the value register returns the live count. The single interrupt output works in one of two modes. In level mode it follows the flag. In pulse mode it stays high for one source-tick period after each countdown. The interrupt enable gates both modes.

Top module: `countdown_timer`

## Requirements
- R1: After reset the count, the reload value, the control register, the flag and `irq_o` are all zero.
- R2: Address 0 is the flag register, with the timer flag at bit 3 and every other bit reading 0. Address 1 is the value register. Address 2 is the control register: enable at bit 7, pulse mode at bit 6, interrupt enable at bit 5 and source select at bits 1:0, with bits 4:2 reading 0. Address 3 reads 0, and writes to it change nothing.
- R3: Source select 00 counts on `tick_i[0]` (4096 Hz), 01 on `tick_i[1]` (64 Hz), 10 on `tick_i[2]` (1 Hz) and 11 on `tick_i[3]` (1/60 Hz). Ticks on the other lines are ignored.
- R4: While the enable bit is 0, the count holds on every tick.
- R5: With the timer enabled, a selected tick decrements a non-zero count. A selected tick at count 0 reloads the last written value. A start value N of at least 1 therefore gives a period of N+1 ticks. A start value of 0 stays at 0 and never ends a countdown.
- R6: Writing the value register loads both the live count and the reload value, and a read in the next cycle returns the new value. The write wins over a selected tick in the same cycle.
- R7: A selected tick that takes the count from 1 to 0 sets the flag, and flag bit 3 reads 1 in the next cycle.
- R8: Hardware never clears the flag. A write to address 0 with bit 3 at 0 clears it. A write with bit 3 at 1 leaves it unchanged. A countdown end in the same cycle as a clearing write wins.
- R9: In level mode (control bit 6 = 0) with interrupts enabled, `irq_o` equals the flag.
- R10: In pulse mode with interrupts enabled, `irq_o` rises in the cycle after a countdown-ending tick. It falls in the cycle after the next selected tick, or as soon as the timer is disabled.
- R11: With the interrupt enable (control bit 5) at 0, `irq_o` stays low while the flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 4 | Tick enables: bit 0 is 4096 Hz, bit 1 is 64 Hz, bit 2 is 1 Hz, bit 3 is 1/60 Hz |
| irq_o | output | 1 | Timer interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit count and four tick sources. This makes every source code and the full register layout reachable. Random value writes stay within 0 to 5, so countdowns end, reload and overlap with flag clears and control changes many times over a few thousand cycles. Directed steps cover the zero start value, a write coinciding with a tick, and switching between the interrupt modes.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int DATA_W    = 8;
  localparam int TF_BIT    = 3;
  localparam int EN_BIT    = 7;
  localparam int PULSE_BIT = 6;
  localparam int IE_BIT    = 5;

  typedef enum logic [1:0] {
    A_FLAGS = 2'd0,
    A_VALUE = 2'd1,
    A_CTRL  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = tick_i[i] & (sel_i == SEL_W'(i));
  end

  assign tick_o = en_i & (|hit);
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
    end else if (tick_i) begin
      // one dwell tick at zero before reload
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

  assign end_o    = tick_i & ~load_i & (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic end_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic pulse_mode_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic tf_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tf_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (end_i)      tf_q <= 1'b1;
      else if (clr_i) tf_q <= 1'b0;

      if (end_i)                pulse_q <= 1'b1;
      else if (tick_i || !en_i) pulse_q <= 1'b0;
    end
  end

  assign flag_o = tf_q;
  assign irq_o  = ie_i & (pulse_mode_i ? pulse_q : tf_q);
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               irq_o
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic             ctrl_en_q, ctrl_pulse_q, ctrl_ie_q;
  logic [SEL_W-1:0] ctrl_src_q;
  logic [CNT_W-1:0] cnt, reload;
  logic             src_tick, count_end, tf;
  logic             wr_flags, wr_value, wr_ctrl, flag_clr;

  assign wr_flags = wr_en_i & (addr_i == A_FLAGS);
  assign wr_value = wr_en_i & (addr_i == A_VALUE);
  assign wr_ctrl  = wr_en_i & (addr_i == A_CTRL);
  assign flag_clr = wr_flags & ~wdata_i[TF_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q    <= 1'b0;
      ctrl_pulse_q <= 1'b0;
      ctrl_ie_q    <= 1'b0;
      ctrl_src_q   <= '0;
    end else if (wr_ctrl) begin
      ctrl_en_q    <= wdata_i[EN_BIT];
      ctrl_pulse_q <= wdata_i[PULSE_BIT];
      ctrl_ie_q    <= wdata_i[IE_BIT];
      ctrl_src_q   <= wdata_i[SEL_W-1:0];
    end
  end

  dtmr_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_tick_sel (
    .tick_i (tick_i),
    .sel_i  (ctrl_src_q),
    .en_i   (ctrl_en_q),
    .tick_o (src_tick)
  );

  dtmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (src_tick),
    .load_i     (wr_value),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt),
    .reload_o   (reload),
    .end_o      (count_end)
  );

  dtmr_irq i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .end_i        (count_end),
    .tick_i       (src_tick),
    .en_i         (ctrl_en_q),
    .clr_i        (flag_clr),
    .pulse_mode_i (ctrl_pulse_q),
    .ie_i         (ctrl_ie_q),
    .flag_o       (tf),
    .irq_o        (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_FLAGS: rdata_o[TF_BIT] = tf;
      A_VALUE: rdata_o = DATA_W'(cnt);
      A_CTRL: begin
        rdata_o[EN_BIT]    = ctrl_en_q;
        rdata_o[PULSE_BIT] = ctrl_pulse_q;
        rdata_o[IE_BIT]    = ctrl_ie_q;
        rdata_o[SEL_W-1:0] = ctrl_src_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             tf,
  input logic             en,
  input logic             pulse_mode,
  input logic             ie,
  input logic             src_tick
);
  logic wv, wc, clr;
  assign wv  = wr_en_i && addr_i == A_VALUE;
  assign wc  = wr_en_i && addr_i == A_CTRL;
  assign clr = wr_en_i && addr_i == A_FLAGS && !wdata_i[TF_BIT];

  p_ctrl_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_CTRL |-> rdata_o[4:2] == 3'b000);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !wv |=> $stable(cnt));

  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_tick && !wv && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_tick && !wv && cnt == '0 |=> cnt == $past(reload));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wv |=> cnt == $past(wdata_i[CNT_W-1:0]) && reload == $past(wdata_i[CNT_W-1:0]));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_tick && !wv && cnt == CNT_W'(1) |=> tf);

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf && !clr |=> tf);

  p_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie && !pulse_mode |-> irq_o == tf);

  p_pulse_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode && irq_o && src_tick && !wc && !(cnt == CNT_W'(1) && !wv) |=> !irq_o);

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !irq_o);
endmodule

bind countdown_timer dtmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .cnt        (cnt),
  .reload     (reload),
  .tf         (tf),
  .en         (ctrl_en_q),
  .pulse_mode (ctrl_pulse_q),
  .ie         (ctrl_ie_q),
  .src_tick   (src_tick)
);

// File: tb/test_countdown_timer.sv
`timescale 1ns/100ps
module test_countdown_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [3:0] tick = 4'd0;
  logic       irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  // reference state
  logic [7:0] m_cnt = 0, m_rel = 0;
  logic       m_tf = 0, m_pulse = 0, m_en = 0, m_pm = 0, m_ie = 0;
  logic [1:0] m_src = 0;

  always #2 clk = ~clk;

  countdown_timer i_countdown_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: exp_read = {4'b0, m_tf, 3'b0};
      2'd1: exp_read = m_cnt;
      2'd2: exp_read = {m_en, m_pm, m_ie, 3'b0, m_src};
      default: exp_read = 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    exp_irq = m_ie & (m_pm ? m_pulse : m_tf);
  endfunction

  task automatic model(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic [3:0] t);
    logic st, ev, wv;
    st = m_en & t[m_src];
    wv = w && a == 2'd1;
    ev = st && !wv && m_cnt == 8'd1;
    if (wv) begin
      m_cnt = d; m_rel = d;
    end else if (st) begin
      m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 8'd1;
    end
    if (ev) m_tf = 1'b1;
    else if (w && a == 2'd0 && !d[3]) m_tf = 1'b0;
    if (ev) m_pulse = 1'b1;
    else if (st || !m_en) m_pulse = 1'b0;
    if (w && a == 2'd2) begin
      m_en = d[7]; m_pm = d[6]; m_ie = d[5]; m_src = d[1:0];
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "irq", {7'b0, irq}, {7'b0, exp_irq()});
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #0.1;
      chk(tag, $sformatf("reg%0d", a), rdata, exp_read(2'(a)));
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                      input logic [3:0] t);
    wr_en = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model(w, a, d, t);
    @(negedge clk);
    wr_en = 1'b0; tick = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1..all watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_71e2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1, 2'd3, 8'hFF, 4'd0);  check_all("R2");
    step(1, 2'd2, 8'hFF, 4'd0);  check_all("R2");
    step(1, 2'd2, 8'h81, 4'd0);  check_all("R2");
    step(1, 2'd1, 8'd3, 4'd0);   check_all("R6");
    step(0, 2'd0, 8'd0, 4'b1101); check_all("R3");
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R3");
    step(1, 2'd2, 8'h83, 4'd0);
    step(0, 2'd0, 8'd0, 4'b1000); check_all("R3");
    step(1, 2'd2, 8'h01, 4'd0);
    step(0, 2'd0, 8'd0, 4'b1111); check_all("R4");
    step(1, 2'd2, 8'hA1, 4'd0);
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R7");
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R9");
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R5");
    step(1, 2'd0, 8'h08, 4'd0);  check_all("R8");
    step(1, 2'd0, 8'h00, 4'd0);  check_all("R8");
    step(1, 2'd1, 8'd9, 4'b0010); check_all("R6");
    step(1, 2'd1, 8'd0, 4'd0);
    step(0, 2'd0, 8'd0, 4'b0010); step(0, 2'd0, 8'd0, 4'b0010); check_all("R5");
    step(1, 2'd2, 8'hE1, 4'd0);
    step(1, 2'd1, 8'd1, 4'd0);
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R10");
    step(0, 2'd0, 8'd0, 4'd0);    check_all("R10");
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R10");
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R10");
    step(1, 2'd2, 8'h61, 4'd0);   check_all("R10");
    step(1, 2'd0, 8'h00, 4'd0);
    step(1, 2'd2, 8'hC1, 4'd0);
    step(1, 2'd1, 8'd1, 4'd0);
    step(0, 2'd0, 8'd0, 4'b0010); check_all("R11");
    step(1, 2'd1, 8'd1, 4'd0);
    step(1, 2'd0, 8'h00, 4'b0010); check_all("R8");

    for (int i = 0; i < 3000; i++) begin
      logic       w;
      logic [1:0] a;
      logic [7:0] d;
      logic [3:0] t;
      w = ($urandom % 8) == 0;
      a = 2'($urandom % 4);
      case (a)
        2'd1:    d = 8'($urandom % 6);
        2'd0:    d = 8'($urandom) & (($urandom % 2) ? 8'hFF : 8'hF7);
        default: d = 8'($urandom) | (($urandom % 4) != 0 ? 8'h80 : 8'h00);
      endcase
      t = 4'($urandom) & 4'($urandom);
      step(w, a, d, t);
      check_all((i % 2) ? "R5" : "R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule